// File: doc/BRIEF.md
# Local-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Every tracked branch has its own short shift register that records its latest outcomes. All branches share one small table of saturating counters, and a branch's own history selects the counter it uses. Branches whose histories hold the same value therefore train the same counter and can disturb each other's predictions.

The fetch side presents a branch id and reads a taken or not-taken guess in the same cycle. The execute side reports the resolved outcome through the update port. A static configuration input decides how unconditional branches are treated. They can be left out of training altogether, or they can train like any other branch, which updates both their own history and the shared table.

Top module: `lhist_pred`

## Requirements
- R1: After reset every history register holds 00 and every counter holds 00, so every branch id predicts not taken (`pred_taken` = 0).
- R2: `pred_taken` is combinational from state. It is 1 when the counter selected by the history of `pred_id` holds 10 or 11, and 0 when it holds 00 or 01.
- R3: An accepted update with `upd_taken` = 1 increments the selected counter by one. A counter at 11 stays at 11.
- R4: An accepted update with `upd_taken` = 0 decrements the selected counter by one. A counter at 00 stays at 00.
- R5: The counter that an update changes is the one indexed by the history of `upd_id` as it was before that update. The counter change and the history shift take effect on the same clock edge.
- R6: On an accepted update the history of `upd_id` shifts right by one place and the new outcome enters the most significant bit (1 = taken). For example, 00 followed by a taken outcome becomes 10.
- R7: An update changes only the history of `upd_id`. Other branches keep their histories but still see the changed shared counter.
- R8: When `upd_uncond` = 1 and `train_uncond` = 0, the update changes neither any history nor any counter.
- R9: When `upd_uncond` = 1 and `train_uncond` = 1, the update behaves exactly like a conditional update.
- R10: When predict and update name the same branch in one cycle, the prediction reflects the state from before the update.
- R11: While `upd_valid` = 0, no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pred_id | input | $clog2(NUM_BR) | Branch to predict |
| pred_taken | output | 1 | Guess for `pred_id`: 1 = taken |
| upd_valid | input | 1 | An outcome is reported this cycle |
| upd_id | input | $clog2(NUM_BR) | Branch whose outcome is reported |
| upd_taken | input | 1 | Resolved outcome: 1 = taken |
| upd_uncond | input | 1 | The reported branch is unconditional |
| train_uncond | input | 1 | 1 = unconditional branches train the predictor; 0 = they are ignored |

## Verification
The bench uses the default build: four branches, two-bit histories and two-bit counters. With these sizes the shared table has only four entries. Each branch can reach every entry within two updates, and a counter goes from one bound to the other in three steps. Short directed loops therefore show cross-branch interference and saturation at both ends, and a long pseudo-random run visits every mix of same-id collisions, bypassed unconditional updates and idle cycles.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  // Operation applied to one pattern-table counter in a cycle
  typedef enum logic [1:0] {
    CTR_HOLD = 2'b00,
    CTR_INC  = 2'b01,
    CTR_DEC  = 2'b10
  } ctr_op_e;

endpackage

// File: rtl/lhp_rst_sync.sv
module lhp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/lhp_hist_bank.sv
module lhp_hist_bank #(
  parameter int NUM_BR = 4,
  parameter int HIST_W = 2,
  localparam int IDW = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDW-1:0]    rd_id,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              upd_en,
  input  logic [IDW-1:0]    upd_id,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] upd_hist
);

  logic [NUM_BR-1:0][HIST_W-1:0] hist_q;
  logic [NUM_BR-1:0][HIST_W-1:0] hist_d;

  for (genvar i = 0; i < NUM_BR; i++) begin : g_br
    logic sel;
    always_comb sel = upd_en && (upd_id == IDW'(i));
    if (HIST_W == 1) begin : g_one
      always_comb hist_d[i] = sel ? upd_taken : hist_q[i];
    end else begin : g_shift
      always_comb hist_d[i] = sel ? {upd_taken, hist_q[i][HIST_W-1:1]} : hist_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign rd_hist  = hist_q[rd_id];
  assign upd_hist = hist_q[upd_id];

  // R6: the newest outcome lands in the top history bit
  a_r6_newest_msb: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> hist_q[$past(upd_id)][HIST_W-1] == $past(upd_taken));

  // R11 (bank side): nothing moves without an enable
  a_r11_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(hist_q));

endmodule

// File: rtl/lhp_pattern_tbl.sv
module lhp_pattern_tbl
  import lhp_pkg::*;
#(
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  localparam int ENTRIES = 1 << HIST_W,
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic              rd_taken,
  input  ctr_op_e           wr_op,
  input  logic [HIST_W-1:0] wr_idx
);

  logic [ENTRIES-1:0][CTR_W-1:0] ctr_q;
  logic [ENTRIES-1:0][CTR_W-1:0] ctr_d;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit;
    always_comb begin
      hit      = (wr_idx == HIST_W'(e));
      ctr_d[e] = ctr_q[e];
      if (hit) begin
        unique case (wr_op)
          CTR_INC: if (ctr_q[e] != CTR_MAX) ctr_d[e] = ctr_q[e] + 1'b1;
          CTR_DEC: if (ctr_q[e] != '0)      ctr_d[e] = ctr_q[e] - 1'b1;
          default: ctr_d[e] = ctr_q[e];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= ctr_d;
  end

  assign rd_taken = ctr_q[rd_idx][CTR_W-1];

  // R3: a taken update never lowers the counter (and so cannot wrap)
  a_r3_inc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == CTR_INC) |=> ctr_q[$past(wr_idx)] >= $past(ctr_q[wr_idx]));

  // R4: a not-taken update never raises the counter (and so cannot wrap)
  a_r4_dec_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == CTR_DEC) |=> ctr_q[$past(wr_idx)] <= $past(ctr_q[wr_idx]));

  // R11: the table holds when no update is accepted
  a_r11_tbl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_op == CTR_HOLD) |=> $stable(ctr_q));

endmodule

// File: rtl/lhist_pred.sv
module lhist_pred
  import lhp_pkg::*;
#(
  parameter int NUM_BR = 4,
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  localparam int IDW = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IDW-1:0] pred_id,
  output logic           pred_taken,
  input  logic           upd_valid,
  input  logic [IDW-1:0] upd_id,
  input  logic           upd_taken,
  input  logic           upd_uncond,
  input  logic           train_uncond
);

  logic              rst_n_int;
  logic              upd_en;
  ctr_op_e           op;
  logic [HIST_W-1:0] rd_hist;
  logic [HIST_W-1:0] upd_hist;

  lhp_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  always_comb begin
    upd_en = upd_valid && (!upd_uncond || train_uncond);
    if (!upd_en)        op = CTR_HOLD;
    else if (upd_taken) op = CTR_INC;
    else                op = CTR_DEC;
  end

  lhp_hist_bank #(.NUM_BR(NUM_BR), .HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rd_id     (pred_id),
    .rd_hist   (rd_hist),
    .upd_en    (upd_en),
    .upd_id    (upd_id),
    .upd_taken (upd_taken),
    .upd_hist  (upd_hist)
  );

  // Pre-update history of the reported branch picks the counter
  lhp_pattern_tbl #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rd_idx   (rd_hist),
    .rd_taken (pred_taken),
    .wr_op    (op),
    .wr_idx   (upd_hist)
  );

  // R8: a bypassed unconditional update leaves the guess for the same id unchanged
  a_r8_bypass: assert property (@(posedge clk) disable iff (!rst_n_int)
    (upd_valid && upd_uncond && !train_uncond) |=> ($stable(pred_id) -> $stable(pred_taken)));

endmodule

// File: tb/lhist_pred_bench.sv
module lhist_pred_bench;

  localparam int NUM_BR = 4;
  localparam int IDW    = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [IDW-1:0] pred_id;
  logic           pred_taken;
  logic           upd_valid;
  logic [IDW-1:0] upd_id;
  logic           upd_taken;
  logic           upd_uncond;
  logic           train_uncond;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Behavioural reference state
  int m_hist [NUM_BR];
  int m_ctr  [4];

  always #10 clk = ~clk;  // 50 MHz

  lhist_pred #(.NUM_BR(NUM_BR)) u_lhist_pred (
    .clk, .rst_n, .pred_id, .pred_taken, .upd_valid,
    .upd_id, .upd_taken, .upd_uncond, .train_uncond
  );

  function automatic bit model_pred(int id);
    return m_ctr[m_hist[id]] >= 2;
  endfunction

  task automatic check(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pred_taken=%0b expected %0b (pred_id=%0d)", req, act, exp, pred_id);
    end
  endtask

  // One cycle: drive at negedge, compare before the edge, then advance the model
  task automatic step(string req, int pid, bit uv, int uid, bit ut, bit uu);
    @(negedge clk);
    pred_id = IDW'(pid); upd_valid = uv; upd_id = IDW'(uid);
    upd_taken = ut; upd_uncond = uu;
    #1 check(req, pred_taken, model_pred(pid));  // R10: pre-update state
    @(posedge clk);
    if (uv && (!uu || train_uncond)) begin
      int ix = m_hist[uid];
      if (ut) m_ctr[ix] = (m_ctr[ix] < 3) ? m_ctr[ix] + 1 : 3;  // R3
      else    m_ctr[ix] = (m_ctr[ix] > 0) ? m_ctr[ix] - 1 : 0;  // R4
      m_hist[uid] = (int'(ut) << 1) | (m_hist[uid] >> 1);      // R6
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pred_id = '0; upd_valid = 0; upd_id = '0;
    upd_taken = 0; upd_uncond = 0; train_uncond = 0;
    foreach (m_hist[i]) m_hist[i] = 0;
    foreach (m_ctr[i])  m_ctr[i]  = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: every id predicts not taken after reset
    for (int i = 0; i < NUM_BR; i++) begin
      @(negedge clk); pred_id = IDW'(i);
      #1 check("R1", pred_taken, 1'b0);
    end

    // R11: idle cycles with junk update fields change nothing
    for (int i = 0; i < 4; i++) step("R11", i, 1'b0, i, 1'b1, 1'b0);

    // R6/R5: 00 + taken gives history 10, counter at index 00 moves
    step("R6", 0, 1'b1, 0, 1'b1, 1'b0);
    step("R5", 0, 1'b0, 0, 1'b0, 1'b0);
    step("R7", 1, 1'b1, 2, 1'b0, 1'b0);  // shared counter, other history

    // Loop-shaped pattern: id0 alternates, id1 unconditional, id2 loop exit
    for (int pass = 0; pass < 2; pass++) begin
      train_uncond = pass[0];
      for (int it = 0; it < 12; it++) begin
        step("R2", 0, 1'b1, 0, it[0], 1'b0);
        if (!it[0]) step(pass[0] ? "R9" : "R8", 1, 1'b1, 1, 1'b1, 1'b1);
        step("R7", 2, 1'b1, 2, it != 11, 1'b0);
      end
    end

    // R3: saturate high on branch 3, then R4: saturate low
    train_uncond = 0;
    for (int i = 0; i < 6; i++) step("R3", 3, 1'b1, 3, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step("R4", 3, 1'b1, 3, 1'b0, 1'b0);

    // R10: same id predicted and updated in one cycle
    for (int i = 0; i < 8; i++) step("R10", 1, 1'b1, 1, i[1], 1'b0);

    // Pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) train_uncond = $urandom_range(0, 1);
      step("R5", $urandom_range(0, NUM_BR-1), $urandom_range(0, 3) != 0,
           $urandom_range(0, NUM_BR-1), $urandom_range(0, 1), $urandom_range(0, 4) == 0);
    end

    done = 1;
    report();
    $finish;
  end

endmodule